// File: doc/BRIEF.md
# Masked Prefix Popcount Unit

This block turns a bit vector into a vector of running counts. For every destination lane i below the active length, the result is the number of set source bits at positions strictly lower than i. Only positions that the mask enables are counted. One strobe on `start` launches an operation. All lanes are computed in the same cycle and land in an output register. A `done` pulse follows one cycle later.

When masking is turned on, lanes whose mask bit is clear are not written. They take the previous destination contents, which the caller supplies on `old_dst`. Lanes at or above the active length are treated the same way. A select input can replace the source with all ones. The block then becomes an index generator: without a mask it yields 0, 1, 2 and so on up to VL-1. With a mask it yields each enabled lane's rank among the enabled lanes.

Top module: `mpc_unit`

## Requirements
- R1: While `rst_n` is low, `dst` reads all zeros and `done` is low; both are cleared asynchronously when `rst_n` falls.
- R2: `done` is high in exactly the cycle after each cycle with `start` high, and low after any cycle with `start` low. Back-to-back strobes keep `done` high.
- R3: With `mask_en` low and `src_ones` low, lane i (field `dst[i*5 +: 5]` in the default configuration) becomes the count of set bits of `src_bits[i-1:0]` for every i below `vl`. Lane 0 becomes 0.
- R4: With `mask_en` high, a lane whose `mask_bits` bit is 0 takes its `old_dst` field. An enabled lane counts only source bits whose mask bit is 1.
- R5: With `mask_en` low, `mask_bits` has no effect on `dst`.
- R6: With `src_ones` high, `src_bits` is ignored and every position counts as set. Unmasked, lane i becomes i for i below `vl`.
- R7: Lanes with index at or above `vl` take their `old_dst` field. A `vl` of 0 leaves every lane at `old_dst`, and a `vl` above 16 behaves as 16.
- R8: `dst` does not change in any cycle without `start`, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Operation strobe, one operation per high cycle |
| src_bits | input | 16 | Source bit vector, bit i belongs to lane i |
| src_ones | input | 1 | Replace the source with all ones |
| mask_en | input | 1 | Apply `mask_bits`; when low every lane is enabled |
| mask_bits | input | 16 | Lane enable mask |
| vl | input | 5 | Active length |
| old_dst | input | 80 | Previous destination contents, five bits per lane, lane i at bits i*5+4..i*5 |
| dst | output | 80 | Registered result, same lane layout as `old_dst` |
| done | output | 1 | One-cycle completion pulse |

## Verification
The properties assume two things about the inputs. Every input is at a known value whenever `start` is high. `start` is raised only once the internally synchronized reset has released, because the properties are gated by that internal reset rather than by the pin. The bench meets both conditions. It waits several cycles after raising `rst_n` before the first strobe, drives every input to a defined value from the first instant, and changes inputs only on the falling clock edge.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

  localparam int unsigned MPC_DEF_LANES = 16;

  // Width of one count field: holds 0..lanes inclusive.
  function automatic int unsigned cnt_width(input int unsigned lanes);
    return $clog2(lanes) + 1;
  endfunction

  // Width of the active-length input: holds 0..lanes inclusive.
  function automatic int unsigned len_width(input int unsigned lanes);
    return $clog2(lanes + 1);
  endfunction

endpackage

// File: rtl/mpc_rst_sync.sv
module mpc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/mpc_lane_enable.sv
module mpc_lane_enable #(
  parameter int unsigned LANES = 16,
  parameter int unsigned LEN_W = 5
) (
  input  logic [LEN_W-1:0] vl,
  input  logic             mask_en,
  input  logic [LANES-1:0] mask_bits,
  output logic [LANES-1:0] count_en,
  output logic [LANES-1:0] write_en
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic in_len;
    // Lane i is active when its index lies below the active length.
    assign in_len      = (vl > LEN_W'(i));
    assign count_en[i] = !mask_en || mask_bits[i];
    assign write_en[i] = in_len && count_en[i];
  end

endmodule

// File: rtl/mpc_prefix_count.sv
module mpc_prefix_count #(
  parameter int unsigned LANES = 16,
  parameter int unsigned CNT_W = 5
) (
  input  logic [LANES-1:0]       hit,
  output logic [LANES*CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] run [LANES];
  logic             unused_top_hit;

  // Exclusive running sum: lane i sees hits of lanes 0..i-1 only.
  assign run[0] = '0;

  for (genvar i = 1; i < LANES; i++) begin : g_step
    assign run[i] = run[i-1] + CNT_W'(hit[i-1]);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_out
    assign cnt[i*CNT_W +: CNT_W] = run[i];
  end

  // The highest lane's hit feeds no lane above it.
  assign unused_top_hit = hit[LANES-1];

endmodule

// File: rtl/mpc_merge.sv
module mpc_merge #(
  parameter int unsigned LANES = 16,
  parameter int unsigned CNT_W = 5
) (
  input  logic [LANES-1:0]       write_en,
  input  logic [LANES*CNT_W-1:0] fresh,
  input  logic [LANES*CNT_W-1:0] prior,
  output logic [LANES*CNT_W-1:0] merged
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign merged[i*CNT_W +: CNT_W] = write_en[i] ? fresh[i*CNT_W +: CNT_W]
                                                  : prior[i*CNT_W +: CNT_W];
  end

endmodule

// File: rtl/mpc_unit.sv
module mpc_unit #(
  parameter int unsigned MAX_VL = mpc_pkg::MPC_DEF_LANES,
  localparam int unsigned CNT_W = mpc_pkg::cnt_width(MAX_VL),
  localparam int unsigned VL_W  = mpc_pkg::len_width(MAX_VL),
  localparam int unsigned DST_W = MAX_VL * CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MAX_VL-1:0] src_bits,
  input  logic              src_ones,
  input  logic              mask_en,
  input  logic [MAX_VL-1:0] mask_bits,
  input  logic [VL_W-1:0]   vl,
  input  logic [DST_W-1:0]  old_dst,
  output logic [DST_W-1:0]  dst,
  output logic              done
);

  logic              rst_sync_n;
  logic [MAX_VL-1:0] count_en;
  logic [MAX_VL-1:0] write_en;
  logic [MAX_VL-1:0] eff_src;
  logic [MAX_VL-1:0] hit;
  logic [DST_W-1:0]  fresh;
  logic [DST_W-1:0]  merged;
  logic [DST_W-1:0]  dst_d;
  logic [DST_W-1:0]  dst_q;
  logic              done_d;
  logic              done_q;

  mpc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mpc_lane_enable #(
    .LANES (MAX_VL),
    .LEN_W (VL_W)
  ) u_lane_enable (
    .vl        (vl),
    .mask_en   (mask_en),
    .mask_bits (mask_bits),
    .count_en  (count_en),
    .write_en  (write_en)
  );

  assign eff_src = src_ones ? {MAX_VL{1'b1}} : src_bits;
  assign hit     = eff_src & count_en;

  mpc_prefix_count #(
    .LANES (MAX_VL),
    .CNT_W (CNT_W)
  ) u_prefix (
    .hit (hit),
    .cnt (fresh)
  );

  mpc_merge #(
    .LANES (MAX_VL),
    .CNT_W (CNT_W)
  ) u_merge (
    .write_en (write_en),
    .fresh    (fresh),
    .prior    (old_dst),
    .merged   (merged)
  );

  // Next-state logic
  always_comb begin
    dst_d  = dst_q;
    done_d = 1'b0;
    if (start) begin
      dst_d  = merged;
      done_d = 1'b1;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dst_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (start) begin
        dst_q <= dst_d;
      end
    end
  end

  assign dst  = dst_q;
  assign done = done_q;

endmodule

// File: rtl/mpc_unit_chk.sv
module mpc_unit_chk #(
  parameter int unsigned MAX_VL = 16,
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned VL_W   = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    src_ones,
  input logic                    mask_en,
  input logic [MAX_VL-1:0]       mask_bits,
  input logic [VL_W-1:0]         vl,
  input logic [MAX_VL*CNT_W-1:0] old_dst,
  input logic [MAX_VL*CNT_W-1:0] dst,
  input logic                    done
);

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) start |=> done); // R2
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n) !start |=> !done); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !start |=> $stable(dst)); // R8

  for (genvar i = 0; i < MAX_VL; i++) begin : g_lane
    AST_BEYOND_LEN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (vl <= VL_W'(i))) |=> (dst[i*CNT_W +: CNT_W] == $past(old_dst[i*CNT_W +: CNT_W]))); // R7
    AST_MASKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (start && mask_en && !mask_bits[i]) |=> (dst[i*CNT_W +: CNT_W] == $past(old_dst[i*CNT_W +: CNT_W]))); // R4
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (vl > VL_W'(i)) && (!mask_en || mask_bits[i])) |=> (dst[i*CNT_W +: CNT_W] <= CNT_W'(i))); // R3
    AST_INDEX_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      (start && src_ones && !mask_en && (vl > VL_W'(i))) |=> (dst[i*CNT_W +: CNT_W] == CNT_W'(i))); // R6
  end

endmodule

bind mpc_unit mpc_unit_chk #(
  .MAX_VL (MAX_VL),
  .CNT_W  (CNT_W),
  .VL_W   (VL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .start     (start),
  .src_ones  (src_ones),
  .mask_en   (mask_en),
  .mask_bits (mask_bits),
  .vl        (vl),
  .old_dst   (old_dst),
  .dst       (dst),
  .done      (done)
);

// File: tb/test_mpc_unit.sv
`timescale 1ns/1ps
module test_mpc_unit;

  localparam int N  = 16;
  localparam int CW = 5;
  localparam int LW = 5;
  localparam int DW = N * CW;

  typedef struct packed {
    logic [N-1:0]  src;
    logic [N-1:0]  msk;
    logic          men;
    logic          one;
    logic [LW-1:0] len;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{16'h0000, 16'hFFFF, 1'b0, 1'b0, 5'd16},
    '{16'hFFFF, 16'h0000, 1'b0, 1'b0, 5'd16},
    '{16'hA5C3, 16'h0000, 1'b0, 1'b0, 5'd16},
    '{16'h8001, 16'h1234, 1'b0, 1'b0, 5'd16},
    '{16'h1234, 16'hF0F0, 1'b1, 1'b0, 5'd16},
    '{16'hFFFF, 16'h5555, 1'b1, 1'b0, 5'd16},
    '{16'h0000, 16'h0000, 1'b0, 1'b1, 5'd16},
    '{16'h0000, 16'h0F0F, 1'b1, 1'b1, 5'd16},
    '{16'hFFFF, 16'h0000, 1'b0, 1'b0, 5'd5},
    '{16'hFFFF, 16'h0000, 1'b0, 1'b0, 5'd31},
    '{16'h3C3C, 16'hFFFF, 1'b1, 1'b0, 5'd0},
    '{16'h7E7E, 16'hAAAA, 1'b1, 1'b1, 5'd9}
  };

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [N-1:0]  src_bits;
  logic          src_ones;
  logic          mask_en;
  logic [N-1:0]  mask_bits;
  logic [LW-1:0] vl;
  logic [DW-1:0] old_dst;
  logic [DW-1:0] dst;
  logic          done;

  int n_chk = 0;
  int n_bad = 0;

  mpc_unit i_mpc_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .src_bits  (src_bits),
    .src_ones  (src_ones),
    .mask_en   (mask_en),
    .mask_bits (mask_bits),
    .vl        (vl),
    .old_dst   (old_dst),
    .dst       (dst),
    .done      (done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Expected result straight from the requirements.
  function automatic logic [DW-1:0] model(input logic [N-1:0] s, input logic [N-1:0] m,
                                          input logic me, input logic on,
                                          input logic [LW-1:0] len, input logic [DW-1:0] prev);
    logic [DW-1:0] r;
    r = prev;
    for (int i = 0; i < N; i++) begin
      if ((i < int'(len)) && (!me || m[i])) begin
        int c;
        c = 0;
        for (int j = 0; j < i; j++) begin
          if ((on || s[j]) && (!me || m[j])) c++;
        end
        r[i*CW +: CW] = CW'(c);
      end
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] make_old(input int k);
    logic [DW-1:0] r;
    for (int i = 0; i < N; i++) r[i*CW +: CW] = CW'((i * 7 + k * 3 + 11) % 32);
    return r;
  endfunction

  task automatic check_vec(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: dst actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: done actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic [DW-1:0] prev);
    src_bits  = v.src;
    mask_bits = v.msk;
    mask_en   = v.men;
    src_ones  = v.one;
    vl        = v.len;
    old_dst   = prev;
  endtask

  // Launch one operation; returns at the falling edge after the result registers.
  task automatic apply(input vec_t v, input logic [DW-1:0] prev);
    @(negedge clk);
    drive(v, prev);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R2: watchdog actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    vec_t          v;
    logic [DW-1:0] prev;
    logic [DW-1:0] exp;
    logic [DW-1:0] held;
    string         tag;

    rst_n = 1'b0;
    start = 1'b0;
    drive('0, '0);
    repeat (3) @(negedge clk);
    check_vec("R1", dst, '0);
    check_bit("R1", done, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_bit("R2", done, 1'b0);

    // Table walk
    for (int k = 0; k < NV; k++) begin
      v    = TBL[k];
      prev = make_old(k);
      apply(v, prev);
      exp = model(v.src, v.msk, v.men, v.one, v.len, prev);
      if (v.len != 5'd16)  tag = "R7";
      else if (v.one)      tag = "R6";
      else if (v.men)      tag = "R4";
      else                 tag = "R3";
      check_vec(tag, dst, exp);
      check_bit("R2", done, 1'b1);
    end

    // R3: unmasked worked example, lanes 0..7 = 0,1,1,1,1,2,2,2
    prev = make_old(20);
    exp  = prev;
    exp[0*CW +: CW] = 5'd0; exp[1*CW +: CW] = 5'd1; exp[2*CW +: CW] = 5'd1;
    exp[3*CW +: CW] = 5'd1; exp[4*CW +: CW] = 5'd1; exp[5*CW +: CW] = 5'd2;
    exp[6*CW +: CW] = 5'd2; exp[7*CW +: CW] = 5'd2;
    apply('{16'h0091, 16'h0000, 1'b0, 1'b0, 5'd8}, prev);
    check_vec("R3", dst, exp);

    // R4: masked worked example, old lanes 0..7 = 9..2
    prev = make_old(21);
    for (int i = 0; i < 8; i++) prev[i*CW +: CW] = CW'(9 - i);
    exp = prev;
    exp[0*CW +: CW] = 5'd0; exp[1*CW +: CW] = 5'd1; exp[2*CW +: CW] = 5'd7;
    exp[3*CW +: CW] = 5'd1; exp[4*CW +: CW] = 5'd5; exp[5*CW +: CW] = 5'd1;
    exp[6*CW +: CW] = 5'd1; exp[7*CW +: CW] = 5'd1;
    apply('{16'h0091, 16'h00EB, 1'b1, 1'b0, 5'd8}, prev);
    check_vec("R4", dst, exp);

    // R5: mask bits ignored while masking is off
    prev = make_old(22);
    apply('{16'h00F0, 16'h0000, 1'b0, 1'b0, 5'd16}, prev);
    check_vec("R5", dst, model(16'h00F0, 16'hFFFF, 1'b0, 1'b0, 5'd16, prev));

    // R8: idle cycles with changing inputs leave dst alone
    held = dst;
    for (int c = 0; c < 3; c++) begin
      drive('{16'h5A5A ^ N'(c), 16'h0F0F, 1'b1, c[0], 5'd16}, make_old(30 + c));
      @(negedge clk);
      check_vec("R8", dst, held);
      check_bit("R2", done, 1'b0);
    end

    // R2: back-to-back strobes
    @(negedge clk);
    prev = make_old(40);
    drive('{16'h0F00, 16'h0000, 1'b0, 1'b0, 5'd16}, prev);
    start = 1'b1;
    @(negedge clk);
    check_vec("R3", dst, model(16'h0F00, 16'h0000, 1'b0, 1'b0, 5'd16, prev));
    prev = make_old(41);
    drive('{16'h0000, 16'h0000, 1'b0, 1'b1, 5'd12}, prev);
    @(negedge clk);
    start = 1'b0;
    check_vec("R6", dst, model(16'h0000, 16'h0000, 1'b0, 1'b1, 5'd12, prev));
    check_bit("R2", done, 1'b1);
    @(negedge clk);
    check_bit("R2", done, 1'b0);

    // R1: reset in mid-run clears at once
    rst_n = 1'b0;
    #1;
    check_vec("R1", dst, '0);
    @(negedge clk);
    check_bit("R1", done, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_vec("R1", dst, '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule